// File: doc/BRIEF.md
# Period and Phase-Interval Fill Counter

This block measures two square waves of the same frequency against one fixed fill clock. It counts fill-clock cycles over each full cycle of channel A, which gives the period. It also counts them from a rising edge on A to the next rising edge on B, which gives the phase interval. Both channels enter the fill-clock domain through a synchronizer. The running counters restart on every rising edge of A, and the same edge latches the finished period together with the phase interval measured in that cycle. Each input cycle therefore yields a fresh, matched pair.

A host reads the pair over a parallel bus. A select input chooses the period or the phase value, and an enable input drives the bus. The host then works out the frequency from the period and the phase as interval·360/period. With the default 20-bit width and a 20 MHz fill clock, one count is 0.05 µs. Inputs between 20 Hz and 20 kHz then give period counts from 1,000 to 1,000,000.

Top module: `fill_phase_counter`

## Requirements
- R1: Each input passes through a two-flop synchronizer. A rising edge is one fill cycle with the synchronized level low followed by one with it high. Both channels have the same latency, so intervals are exact counts of fill cycles between input edges.
- R2: On each rising edge of A after the first one since reset, the period hold takes the number of fill cycles since the previous rising edge of A.
- R3: The phase interval is the number of fill cycles from a rising edge of A to the first rising edge of B after it. If both channels rise in the same cycle, the interval is 0. The interval is latched into the phase hold at the following rising edge of A, in the same cycle as its matching period.
- R4: A rising edge of B has no effect while no phase window is open. This covers edges before the first A edge after reset and further B edges after the first one in a cycle.
- R5: If a cycle of A ends with no B edge in it, the phase hold takes all ones (2^W−1) and the overflow flag is set.
- R6: A running counter saturates at 2^W−1 instead of wrapping. The period counter does this once armed, and the phase counter while its window is open. Saturation sets the overflow flag, which is sticky until reset.
- R7: The data-valid flag is low until the first complete period/phase pair is latched. This happens on the second A edge after reset, and the flag then stays high until reset.
- R8: The read bus is registered with one cycle of latency. With enable high, select 0 gives the period hold and select 1 gives the phase hold. With enable low, the bus reads all zeros.
- R9: A synchronous active-high reset clears both holds, both flags, the read bus and the armed state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fill clock |
| rst | input | 1 | Synchronous active-high reset |
| sig_a | input | 1 | Reference square wave (channel A) |
| sig_b | input | 1 | Compared square wave (channel B) |
| rd_en | input | 1 | Read enable; low forces the bus to zero |
| rd_sel | input | 1 | 0 selects the period, 1 selects the phase interval |
| rd_data | output | CNT_W | Registered read bus |
| data_ok | output | 1 | First matched pair has been latched |
| ovf | output | 1 | Sticky flag for saturation or a missing B edge |

## Verification
Several corner cases are targeted directly.

- **B edges before any A edge.** If these opened the window, the first phase value would be wrong.
- **Coincident A and B edges.** A design that mishandled them would report a full period instead of 0.
- **A second B pulse inside one cycle.** A design that let it restart the capture would report the later edge.
- **A cycle with B held low.** It must produce the all-ones marker and the overflow flag, not a stale interval.
- **A period longer than the counter range.** It must latch the saturated value rather than a wrapped small count.

The data-valid flag is checked on both sides of the second A edge. Reset is checked for clearing both the holds and the sticky flags.

// File: rtl/fpc_pkg.sv
package fpc_pkg;
  // Read-select encoding of the host bus
  typedef enum logic {
    SEL_PERIOD = 1'b0,
    SEL_PHASE  = 1'b1
  } rd_sel_e;

  localparam int DEFAULT_CNT_W = 20;
  localparam int DEFAULT_SYNC  = 2;
endpackage

// File: rtl/fpc_edge_sync.sv
// Synchronizer chain followed by a rising-edge detector.
module fpc_edge_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic din,
  output logic rise
);
  logic [STAGES-1:0] chain_q;
  logic              last_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      chain_q <= '0;
      last_q  <= 1'b0;
    end else begin
      chain_q <= {chain_q[STAGES-2:0], din};
      last_q  <= chain_q[STAGES-1];
    end
  end

  assign rise = chain_q[STAGES-1] & ~last_q;
endmodule

// File: rtl/fpc_sat_counter.sv
// Running fill counter: restart loads 1, otherwise counts up and holds at the top.
module fpc_sat_counter #(
  parameter int W = 20
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         restart,
  output logic [W-1:0] count,
  output logic         at_top
);
  localparam logic [W-1:0] TOP = {W{1'b1}};

  always_ff @(posedge clk) begin
    if (rst)               count <= '0;
    else if (restart)      count <= {{(W-1){1'b0}}, 1'b1};
    else if (count != TOP) count <= count + 1'b1;
  end

  // High when the counter would have passed the top this cycle
  assign at_top = (count == TOP) && !restart;
endmodule

// File: rtl/fpc_capture.sv
// Window tracking, per-cycle latching and status flags.
module fpc_capture #(
  parameter int W = 20
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         a_rise,
  input  logic         b_rise,
  input  logic [W-1:0] per_cnt,
  input  logic [W-1:0] ph_cnt,
  input  logic         per_top,
  input  logic         ph_top,
  output logic [W-1:0] per_hold,
  output logic [W-1:0] ph_hold,
  output logic         data_ok,
  output logic         ovf
);
  localparam logic [W-1:0] TOP = {W{1'b1}};

  logic         armed_q;
  logic         window_q;
  logic         got_q;
  logic [W-1:0] ph_meas_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      armed_q   <= 1'b0;
      window_q  <= 1'b0;
      got_q     <= 1'b0;
      ph_meas_q <= '0;
      per_hold  <= '0;
      ph_hold   <= '0;
      data_ok   <= 1'b0;
      ovf       <= 1'b0;
    end else begin
      if (a_rise) begin
        armed_q <= 1'b1;
        if (armed_q) begin
          per_hold <= per_cnt;
          ph_hold  <= got_q ? ph_meas_q : TOP;
          data_ok  <= 1'b1;
          if (!got_q) ovf <= 1'b1;
        end
        if (b_rise) begin
          window_q  <= 1'b0;
          got_q     <= 1'b1;
          ph_meas_q <= '0;
        end else begin
          window_q <= 1'b1;
          got_q    <= 1'b0;
        end
      end else if (b_rise && window_q) begin
        window_q  <= 1'b0;
        got_q     <= 1'b1;
        ph_meas_q <= ph_cnt;
      end
      if ((armed_q && per_top) || (window_q && ph_top)) ovf <= 1'b1;
    end
  end
endmodule

// File: rtl/fill_phase_counter.sv
module fill_phase_counter #(
  parameter int CNT_W       = fpc_pkg::DEFAULT_CNT_W,
  parameter int SYNC_STAGES = fpc_pkg::DEFAULT_SYNC
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             sig_a,
  input  logic             sig_b,
  input  logic             rd_en,
  input  logic             rd_sel,
  output logic [CNT_W-1:0] rd_data,
  output logic             data_ok,
  output logic             ovf
);
  logic             a_rise, b_rise;
  logic [CNT_W-1:0] per_cnt, ph_cnt;
  logic             per_top, ph_top;
  logic [CNT_W-1:0] per_hold, ph_hold;

  fpc_edge_sync #(.STAGES(SYNC_STAGES)) u_sync_a (
    .clk(clk), .rst(rst), .din(sig_a), .rise(a_rise));
  fpc_edge_sync #(.STAGES(SYNC_STAGES)) u_sync_b (
    .clk(clk), .rst(rst), .din(sig_b), .rise(b_rise));

  fpc_sat_counter #(.W(CNT_W)) u_per_cnt (
    .clk(clk), .rst(rst), .restart(a_rise), .count(per_cnt), .at_top(per_top));
  fpc_sat_counter #(.W(CNT_W)) u_ph_cnt (
    .clk(clk), .rst(rst), .restart(a_rise), .count(ph_cnt), .at_top(ph_top));

  fpc_capture #(.W(CNT_W)) u_cap (
    .clk(clk), .rst(rst), .a_rise(a_rise), .b_rise(b_rise),
    .per_cnt(per_cnt), .ph_cnt(ph_cnt), .per_top(per_top), .ph_top(ph_top),
    .per_hold(per_hold), .ph_hold(ph_hold), .data_ok(data_ok), .ovf(ovf));

  always_ff @(posedge clk) begin
    if (rst)                            rd_data <= '0;
    else if (!rd_en)                    rd_data <= '0;
    else if (rd_sel == fpc_pkg::SEL_PHASE) rd_data <= ph_hold;
    else                                rd_data <= per_hold;
  end
endmodule

// File: rtl/fpc_checker.sv
module fpc_checker #(
  parameter int CNT_W = 20
) (
  input logic             clk,
  input logic             rst,
  input logic             rd_en,
  input logic [CNT_W-1:0] rd_data,
  input logic             data_ok,
  input logic             ovf,
  input logic             a_rise,
  input logic [CNT_W-1:0] per_cnt
);
  localparam logic [CNT_W-1:0] TOP = {CNT_W{1'b1}};

  // R8
  rd_off_zero_chk: assert property (@(posedge clk) disable iff (rst)
    !rd_en |=> rd_data == '0);
  // R7
  data_ok_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    data_ok |=> data_ok);
  // R7
  data_ok_rise_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(data_ok) |-> $past(a_rise));
  // R6
  ovf_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    ovf |=> ovf);
  // R6
  per_sat_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (per_cnt == TOP && !a_rise) |=> per_cnt == TOP);
  // R2
  per_restart_chk: assert property (@(posedge clk) disable iff (rst)
    a_rise |=> per_cnt == 1);
endmodule

bind fill_phase_counter fpc_checker #(.CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst(rst), .rd_en(rd_en), .rd_data(rd_data),
  .data_ok(data_ok), .ovf(ovf), .a_rise(a_rise), .per_cnt(per_cnt));

// File: tb/fill_phase_counter_test.sv
module fill_phase_counter_test;
  localparam int W = 12;
  localparam logic [W-1:0] TOP = {W{1'b1}};
  localparam int NV = 5;
  localparam int VEC_N [NV] = '{40, 64, 100, 1000, 30};
  localparam int VEC_D [NV] = '{5, 0, 31, 499, 14};

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic sa = 1'b0, sb = 1'b0, rd_en = 1'b0, rd_sel = 1'b0;
  logic [W-1:0] rd_data;
  logic data_ok, ovf;
  int n_run = 0, n_fail = 0;
  bit done = 0;

  always #10 clk = ~clk;

  fill_phase_counter #(.CNT_W(W)) uut (
    .clk(clk), .rst(rst), .sig_a(sa), .sig_b(sb), .rd_en(rd_en),
    .rd_sel(rd_sel), .rd_data(rd_data), .data_ok(data_ok), .ovf(ovf));

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(input string req, input int act, input int exp);
    n_run++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic rd(input logic sel, output int val);
    rd_en = 1'b1; rd_sel = sel;
    tick(1);
    val = rd_data;
  endtask

  // Periods of A with B delayed by d, then a closing A edge with its own B edge
  task automatic train(input int n, input int d, input int periods, input bit with_b);
    sa = 0; sb = 0; tick(4);
    for (int p = 0; p < periods; p++) begin
      for (int i = 0; i < n; i++) begin
        sa = (i < n / 2);
        sb = with_b && (i >= d) && (i < d + n / 2);
        tick(1);
      end
    end
    sa = 1; sb = with_b && (d == 0);
    if (with_b && d > 0) begin tick(d); sb = 1; end
    tick(8);
  endtask

  initial begin
    int v;
    tick(4);
    rst = 0;
    tick(1);
    // R9 reset state
    check("R9 data_ok after reset", data_ok, 0);
    check("R9 ovf after reset", ovf, 0);
    rd(1'b0, v); check("R9 period hold after reset", v, 0);

    // R4: B edges before any A edge are ignored
    repeat (2) begin sb = 1; tick(3); sb = 0; tick(3); end
    rd(1'b1, v); check("R4 phase after early B edges", v, 0);
    // R7: one A edge alone does not make a pair
    sa = 1; tick(3); sb = 1; tick(8);
    check("R7 data_ok after first A edge", data_ok, 0);

    // R1 R2 R3: table of period / delay vectors
    for (int k = 0; k < NV; k++) begin
      train(VEC_N[k], VEC_D[k], 3, 1'b1);
      rd(1'b0, v); check($sformatf("R2 period vec %0d", k), v, VEC_N[k]);
      rd(1'b1, v); check($sformatf("R3 phase vec %0d (R1)", k), v, VEC_D[k]);
      check($sformatf("R6 no overflow vec %0d", k), ovf, 0);
      check($sformatf("R7 data_ok vec %0d", k), data_ok, 1);
    end

    // R4: a second B pulse in the same cycle does not move the phase
    sa = 0; sb = 0; tick(4);
    for (int p = 0; p < 2; p++)
      for (int i = 0; i < 50; i++) begin
        sa = (i < 25);
        sb = (i >= 5 && i < 10) || (i >= 20 && i < 25);
        tick(1);
      end
    sa = 1; tick(5); sb = 1; tick(8);
    rd(1'b1, v); check("R4 phase with extra B pulse", v, 5);
    rd(1'b0, v); check("R2 period with extra B pulse", v, 50);

    // R8: enable low forces zeros
    rd_en = 0; tick(1);
    check("R8 bus with enable low", rd_data, 0);

    // R5: B held low for whole cycles
    train(40, 0, 3, 1'b0);
    rd(1'b1, v); check("R5 phase marker on missing B", v, TOP);
    rd(1'b0, v); check("R5 period on missing B", v, 40);
    check("R5 ovf on missing B", ovf, 1);

    // R9: reset clears sticky state
    rst = 1; tick(3); rst = 0; sa = 0; sb = 0; tick(4);
    check("R9 ovf cleared", ovf, 0);
    check("R9 data_ok cleared", data_ok, 0);
    rd(1'b1, v); check("R9 phase hold cleared", v, 0);

    // R6: period longer than the counter range saturates
    sa = 1; tick(3); sb = 1; tick(TOP + 5);
    sa = 0; sb = 0; tick(4);
    sa = 1; tick(8);
    rd(1'b0, v); check("R6 saturated period", v, TOP);
    rd(1'b1, v); check("R3 phase in long cycle", v, 3);
    check("R6 ovf on saturation", ovf, 1);

    done = 1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_run++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule